// File: doc/BRIEF.md
# Multi-Pixel Video Output Packer

The packer accepts a video stream at one pixel per clock and gathers it onto a wide output bus that carries one, two or four pixels per clock. Each pixel arrives as three component values that are right-aligned in 16-bit inputs. A runtime depth code selects how many of those bits are meaningful. A format bit selects full-chroma RGB/YCbCr 4:4:4 or sub-sampled YCbCr 4:2:2. The block places every component at the most significant end of its field inside a fixed 48-bit lane. Unused low bits are zero.

The upstream source marks the last pixel of every line with an end-of-line flag on that same pixel. When a line's length is not a multiple of the lane count, the packer flushes the partly filled word at end-of-line. A per-lane valid vector shows which lanes carry active pixels, and a one-clock strobe marks each new word. The lane count, depth and format are captured on the first pixel of each line. A line is always packed under one setting.

Top module: `vid_lane_packer`

## Requirements
- R1: In 4:4:4 mode (`cfg_fmt`=0), component `in_c0` occupies lane bits [47:32], `in_c1` bits [31:16] and `in_c2` bits [15:0]. Each value is MSB-aligned in its 16-bit field with zero low bits. Input bits above the selected depth are discarded. The depth codes are 0=6, 1=8, 2=10, 3=12 and 4=16 bits per component.
- R2: In 4:2:2 mode (`cfg_fmt`=1), Y (`in_c0`) is MSB-aligned at lane bit 47 within [47:24]. The chroma sample is MSB-aligned at bit 23 within [23:0]. The chroma is Cb (`in_c1`) on even pixel positions of a line and Cr (`in_c2`) on odd ones, counting from 0.
- R3: Within a word, the earliest pixel occupies lane 0 (`out_data[47:0]`), and each later pixel occupies the next higher lane.
- R4: Lane mode codes are 0=1 lane, 1=2 lanes and 2 or 3=4 lanes. A word is emitted each time that many pixels of a line have been collected.
- R5: An end-of-line pixel that leaves the word short flushes it at once. Lanes without a pixel have their valid bit low and their data all zero. Valid bits are always contiguous from lane 0.
- R6: The Cb/Cr alternation restarts at Cb on the first pixel after every end-of-line.
- R7: Lane mode, depth and format are taken on the first pixel of a line. Changes during the line take effect on the next line.
- R8: `out_word_vld` is high for one clock, in the cycle after the clock edge that accepts a word's last pixel. `out_data` and `out_lane_vld` hold their values between words.
- R9: Synchronous active-high `rst` clears the lane fill position, the chroma phase, the output data and all valid outputs. The first pixel after reset starts a new word in lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_eol | input | 1 | Current pixel is the last of its line (qualified by in_valid) |
| in_c0 | input | 16 | Component 0 (R or Y), right-aligned |
| in_c1 | input | 16 | Component 1 (G or Cb), right-aligned |
| in_c2 | input | 16 | Component 2 (B or Cr), right-aligned |
| cfg_depth | input | 3 | Bits-per-component code |
| cfg_fmt | input | 1 | 0 = 4:4:4, 1 = 4:2:2 |
| cfg_mode | input | 2 | Lanes per word code |
| out_data | output | 192 | Packed word, lane i at bits [48i+47:48i] |
| out_lane_vld | output | 4 | Per-lane active-pixel flags |
| out_word_vld | output | 1 | New word strobe |

## Verification
Every result is due one clock after the edge that accepts the pixel closing a word. The bench drives each pixel on a falling edge and reads the outputs on the next falling edge, so exactly one rising edge lies between stimulus and check. At that sample it checks that the strobe is present exactly when a word must close and absent otherwise. Data and valids are compared only at a strobe, or to confirm that they are unchanged when no strobe is expected.

// File: rtl/vpk_pkg.sv
package vpk_pkg;

  typedef enum logic [0:0] {
    FMT_444 = 1'b0,
    FMT_422 = 1'b1
  } fmt_e;

  // Bits per component for a depth code, clamped to the field width.
  function automatic int depth_bits(input logic [2:0] code, input int max_w);
    int w;
    case (code)
      3'd0:    w = 6;
      3'd1:    w = 8;
      3'd2:    w = 10;
      3'd3:    w = 12;
      default: w = 16;
    endcase
    if (w > max_w) w = max_w;
    return w;
  endfunction

endpackage

// File: rtl/vpk_formatter.sv
module vpk_formatter #(
  parameter int COMP_W = 16
) (
  input  logic [2:0]            depth_code,
  input  vpk_pkg::fmt_e         fmt,
  input  logic                  cr_phase,
  input  logic [COMP_W-1:0]     c0,
  input  logic [COMP_W-1:0]     c1,
  input  logic [COMP_W-1:0]     c2,
  output logic [3*COMP_W-1:0]   lane
);
  localparam int LANE_W = 3 * COMP_W;
  localparam int HALF_W = LANE_W / 2;
  localparam int PAD_W  = HALF_W - COMP_W;
  localparam int SH_W   = $clog2(COMP_W + 1);

  logic [SH_W-1:0]   sh;
  logic [COMP_W-1:0] f0, f1, f2, chroma;

  // Left shift drops bits above the depth and zero-fills below it.
  assign sh     = SH_W'(COMP_W - vpk_pkg::depth_bits(depth_code, COMP_W));
  assign f0     = c0 << sh;
  assign f1     = c1 << sh;
  assign f2     = c2 << sh;
  assign chroma = cr_phase ? f2 : f1;

  always_comb begin
    if (fmt == vpk_pkg::FMT_422)
      lane = {f0, {PAD_W{1'b0}}, chroma, {PAD_W{1'b0}}};
    else
      lane = {f0, f1, f2};
  end
endmodule

// File: rtl/vpk_linectl.sv
module vpk_linectl #(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_eol,
  input  logic [2:0]        depth_in,
  input  vpk_pkg::fmt_e     fmt_in,
  input  logic [MODE_W-1:0] mode_in,
  output logic [2:0]        depth_eff,
  output vpk_pkg::fmt_e     fmt_eff,
  output logic [MODE_W-1:0] mode_eff,
  output logic              cr_phase
);
  logic              line_start;
  logic [2:0]        depth_q;
  vpk_pkg::fmt_e     fmt_q;
  logic [MODE_W-1:0] mode_q;

  assign depth_eff = line_start ? depth_in : depth_q;
  assign fmt_eff   = line_start ? fmt_in   : fmt_q;
  assign mode_eff  = line_start ? mode_in  : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_start <= 1'b1;
      cr_phase   <= 1'b0;
      depth_q    <= '0;
      fmt_q      <= vpk_pkg::FMT_444;
      mode_q     <= '0;
    end else if (in_valid) begin
      line_start <= in_eol;
      cr_phase   <= in_eol ? 1'b0 : ~cr_phase;
      if (line_start) begin
        depth_q <= depth_in;
        fmt_q   <= fmt_in;
        mode_q  <= mode_in;
      end
    end
  end
endmodule

// File: rtl/vpk_lane_accum.sv
module vpk_lane_accum #(
  parameter int LANE_W    = 48,
  parameter int MAX_LANES = 4,
  parameter int MODE_W    = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          px_valid,
  input  logic                          px_eol,
  input  logic [MODE_W-1:0]             mode,
  input  logic [LANE_W-1:0]             px_lane,
  output logic [MAX_LANES*LANE_W-1:0]   out_data,
  output logic [MAX_LANES-1:0]          out_lane_vld,
  output logic                          out_word_vld
);
  localparam int CNT_W   = $clog2(MAX_LANES);
  localparam int MAX_LOG = $clog2(MAX_LANES);

  logic [CNT_W-1:0]  fill;
  logic [CNT_W-1:0]  last_idx;
  logic [MODE_W-1:0] mode_cl;
  logic              closing;
  logic [LANE_W-1:0] acc   [MAX_LANES];
  logic [LANE_W-1:0] out_q [MAX_LANES];

  assign mode_cl  = (int'(mode) > MAX_LOG) ? MODE_W'(MAX_LOG) : mode;
  assign last_idx = CNT_W'((1 << mode_cl) - 1);
  assign closing  = px_eol || (fill == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      fill         <= '0;
      out_word_vld <= 1'b0;
    end else begin
      out_word_vld <= px_valid && closing;
      if (px_valid) fill <= closing ? '0 : fill + 1'b1;
    end
  end

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        acc[i]          <= '0;
        out_q[i]        <= '0;
        out_lane_vld[i] <= 1'b0;
      end else if (px_valid) begin
        if (closing) begin
          acc[i]          <= '0;
          out_q[i]        <= (CNT_W'(i) == fill) ? px_lane : acc[i];
          out_lane_vld[i] <= (CNT_W'(i) <= fill);
        end else if (CNT_W'(i) == fill) begin
          acc[i] <= px_lane;
        end
      end
    end
    assign out_data[i*LANE_W +: LANE_W] = out_q[i];
  end
endmodule

// File: rtl/vid_lane_packer.sv
module vid_lane_packer #(
  parameter int COMP_W    = 16,
  parameter int MAX_LANES = 4,
  parameter int LANE_W    = 3 * COMP_W,
  parameter int MODE_W    = $clog2($clog2(MAX_LANES) + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic                        in_eol,
  input  logic [COMP_W-1:0]           in_c0,
  input  logic [COMP_W-1:0]           in_c1,
  input  logic [COMP_W-1:0]           in_c2,
  input  logic [2:0]                  cfg_depth,
  input  logic                        cfg_fmt,
  input  logic [MODE_W-1:0]           cfg_mode,
  output logic [MAX_LANES*LANE_W-1:0] out_data,
  output logic [MAX_LANES-1:0]        out_lane_vld,
  output logic                        out_word_vld
);
  logic [2:0]        depth_eff;
  vpk_pkg::fmt_e     fmt_eff;
  logic [MODE_W-1:0] mode_eff;
  logic              cr_phase;
  logic [LANE_W-1:0] px_lane;

  vpk_linectl #(.MODE_W(MODE_W)) u_line (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_eol    (in_eol),
    .depth_in  (cfg_depth),
    .fmt_in    (vpk_pkg::fmt_e'(cfg_fmt)),
    .mode_in   (cfg_mode),
    .depth_eff (depth_eff),
    .fmt_eff   (fmt_eff),
    .mode_eff  (mode_eff),
    .cr_phase  (cr_phase)
  );

  vpk_formatter #(.COMP_W(COMP_W)) u_fmt (
    .depth_code (depth_eff),
    .fmt        (fmt_eff),
    .cr_phase   (cr_phase),
    .c0         (in_c0),
    .c1         (in_c1),
    .c2         (in_c2),
    .lane       (px_lane)
  );

  vpk_lane_accum #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES), .MODE_W(MODE_W)) u_acc (
    .clk          (clk),
    .rst          (rst),
    .px_valid     (in_valid),
    .px_eol       (in_eol),
    .mode         (mode_eff),
    .px_lane      (px_lane),
    .out_data     (out_data),
    .out_lane_vld (out_lane_vld),
    .out_word_vld (out_word_vld)
  );
endmodule

// File: rtl/vpk_checker.sv
module vpk_checker #(
  parameter int LANE_W    = 48,
  parameter int MAX_LANES = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic [MAX_LANES*LANE_W-1:0] out_data,
  input logic [MAX_LANES-1:0]        out_lane_vld,
  input logic                        out_word_vld
);
  // R9: reset leaves no valid output behind.
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (out_lane_vld == '0 && !out_word_vld));

  // R8: outputs hold between words.
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!out_word_vld && !$past(rst)) |-> ($stable(out_data) && $stable(out_lane_vld)));

  // R8: every word carries at least lane 0.
  p_word_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
    out_word_vld |-> out_lane_vld[0]);

  // R4: a word only follows an accepted pixel.
  p_word_source_r4: assert property (@(posedge clk) disable iff (rst)
    out_word_vld |-> $past(in_valid));

  // R5: valid lanes are contiguous from lane 0.
  p_contig_r5: assert property (@(posedge clk) disable iff (rst)
    ((out_lane_vld + 1'b1) & out_lane_vld) == '0);

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_empty
    // R5: an empty lane carries zero data.
    p_empty_zero_r5: assert property (@(posedge clk) disable iff (rst)
      !out_lane_vld[i] |-> (out_data[i*LANE_W +: LANE_W] == '0));
  end
endmodule

bind vid_lane_packer vpk_checker #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .out_data     (out_data),
  .out_lane_vld (out_lane_vld),
  .out_word_vld (out_word_vld)
);

// File: tb/vid_lane_packer_test.sv
`timescale 1ns/100ps
module vid_lane_packer_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0, in_eol = 1'b0;
  logic [15:0]  in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic [2:0]   cfg_depth = 3'd4;
  logic         cfg_fmt = 1'b0;
  logic [1:0]   cfg_mode = 2'd0;
  logic [191:0] out_data;
  logic [3:0]   out_lane_vld;
  logic         out_word_vld;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  vid_lane_packer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_eol(in_eol),
    .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
    .cfg_depth(cfg_depth), .cfg_fmt(cfg_fmt), .cfg_mode(cfg_mode),
    .out_data(out_data), .out_lane_vld(out_lane_vld), .out_word_vld(out_word_vld)
  );

  // {depth[99:97], fmt[96], c0[95:80], c1[79:64], c2[63:48], expected lane[47:0]}
  localparam logic [99:0] TBL [8] = '{
    {3'd4, 1'b0, 16'h1234, 16'hABCD, 16'h00FF, 48'h1234ABCD00FF},
    {3'd1, 1'b0, 16'hFFA5, 16'h003C, 16'h0001, 48'hA5003C000100},
    {3'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h002A, 48'hFC000400A800},
    {3'd2, 1'b0, 16'h03FF, 16'h0001, 16'h0200, 48'hFFC000408000},
    {3'd3, 1'b0, 16'h0ABC, 16'h0123, 16'h0FFF, 48'hABC01230FFF0},
    {3'd1, 1'b1, 16'h0080, 16'h0011, 16'h0022, 48'h800000110000},
    {3'd4, 1'b1, 16'hBEEF, 16'h1357, 16'h2468, 48'hBEEF00135700},
    {3'd2, 1'b1, 16'h03FF, 16'h0001, 16'h0300, 48'hFFC000004000}
  };

  task automatic chk(input string tag, input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drive one pixel at a falling edge; check the strobe one rising edge later.
  task automatic px(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                    input logic eol, input logic exp_w, input string tag);
    in_c0 = a; in_c1 = b; in_c2 = c; in_eol = eol; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_eol = 1'b0;
    chk({tag, " R8 strobe"}, {191'd0, out_word_vld}, {191'd0, exp_w});
  endtask

  function automatic logic [47:0] ln(input int k);
    return {16'h1000 + 16'(k), 16'h2000 + 16'(k), 16'h3000 + 16'(k)};
  endfunction

  initial begin
    logic [191:0] held;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset vld", {188'd0, out_lane_vld}, '0);
    chk("R9 reset strobe", {191'd0, out_word_vld}, '0);
    chk("R9 reset data", out_data, '0);
    rst = 1'b0;
    @(negedge clk);

    // Table walk: single lane, every pixel ends its line (R1, R2)
    cfg_mode = 2'd0;
    for (int i = 0; i < 8; i++) begin
      cfg_depth = TBL[i][99:97];
      cfg_fmt   = TBL[i][96];
      px(TBL[i][95:80], TBL[i][79:64], TBL[i][63:48], 1'b1, 1'b1, TBL[i][96] ? "R2" : "R1");
      chk(TBL[i][96] ? "R2 lane" : "R1 lane", out_data, {144'd0, TBL[i][47:0]});
      chk("R4 single vld", {188'd0, out_lane_vld}, 192'd1);
    end

    // Two lanes, line of 5 pixels (R3, R4, R5)
    cfg_depth = 3'd4; cfg_fmt = 1'b0; cfg_mode = 2'd1;
    px(ln(0)[47:32], ln(0)[31:16], ln(0)[15:0], 1'b0, 1'b0, "R4 2L p0");
    px(ln(1)[47:32], ln(1)[31:16], ln(1)[15:0], 1'b0, 1'b1, "R4 2L p1");
    chk("R3 2L order", out_data, {96'd0, ln(1), ln(0)});
    chk("R4 2L vld", {188'd0, out_lane_vld}, 192'h3);
    held = out_data;
    px(ln(2)[47:32], ln(2)[31:16], ln(2)[15:0], 1'b0, 1'b0, "R4 2L p2");
    chk("R8 hold mid-word", out_data, held);
    px(ln(3)[47:32], ln(3)[31:16], ln(3)[15:0], 1'b0, 1'b1, "R4 2L p3");
    chk("R3 2L second", out_data, {96'd0, ln(3), ln(2)});
    px(ln(4)[47:32], ln(4)[31:16], ln(4)[15:0], 1'b1, 1'b1, "R5 2L p4");
    chk("R5 2L partial data", out_data, {144'd0, ln(4)});
    chk("R5 2L partial vld", {188'd0, out_lane_vld}, 192'h1);

    // Idle cycles: no strobe, outputs held (R8)
    held = out_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 idle strobe", {191'd0, out_word_vld}, '0);
      chk("R8 idle hold", out_data, held);
    end

    // Four lanes, line of 6 pixels (R3, R4, R5)
    cfg_mode = 2'd2;
    for (int k = 0; k < 6; k++)
      px(ln(k)[47:32], ln(k)[31:16], ln(k)[15:0], k == 5, k == 3 || k == 5, "R4 4L");
    chk("R5 4L partial vld", {188'd0, out_lane_vld}, 192'h3);
    chk("R5 4L partial data", out_data, {96'd0, ln(5), ln(4)});

    // 4:2:2 chroma alternation and restart (R2, R6)
    cfg_mode = 2'd0; cfg_fmt = 1'b1; cfg_depth = 3'd4;
    px(16'hAAAA, 16'h0B0B, 16'h0C0C, 1'b0, 1'b1, "R2 p0");
    chk("R2 Cb even", out_data, {144'd0, 48'hAAAA000B0B00});
    px(16'hAAAA, 16'h0B0B, 16'h0C0C, 1'b0, 1'b1, "R2 p1");
    chk("R2 Cr odd", out_data, {144'd0, 48'hAAAA000C0C00});
    px(16'hAAAA, 16'h0B0B, 16'h0C0C, 1'b1, 1'b1, "R2 p2");
    chk("R2 Cb p2", out_data, {144'd0, 48'hAAAA000B0B00});
    px(16'h5555, 16'h0B0B, 16'h0C0C, 1'b0, 1'b1, "R6 p0");
    chk("R6 restart Cb", out_data, {144'd0, 48'h5555000B0B00});
    px(16'h5555, 16'h0B0B, 16'h0C0C, 1'b1, 1'b1, "R6 p1");
    chk("R6 then Cr", out_data, {144'd0, 48'h5555000C0C00});

    // Mid-line configuration change (R7)
    cfg_fmt = 1'b0; cfg_depth = 3'd4; cfg_mode = 2'd2;
    px(16'h1234, 16'h00AB, 16'h0001, 1'b0, 1'b0, "R7 p0");
    cfg_mode = 2'd0; cfg_depth = 3'd1;
    px(16'h1234, 16'h00AB, 16'h0001, 1'b0, 1'b0, "R7 p1 mode held");
    px(16'h1234, 16'h00AB, 16'h0001, 1'b1, 1'b1, "R7 p2");
    chk("R7 vld", {188'd0, out_lane_vld}, 192'h7);
    chk("R7 depth held", out_data[95:48], {144'd0, 48'h123400AB0001});
    px(16'h1234, 16'h00AB, 16'h0001, 1'b1, 1'b1, "R7 next line");
    chk("R7 new depth", out_data, {144'd0, 48'h3400AB000100});
    chk("R7 new mode vld", {188'd0, out_lane_vld}, 192'h1);

    // Reset mid-line clears fill position (R9)
    cfg_depth = 3'd4; cfg_mode = 2'd2;
    px(ln(7)[47:32], ln(7)[31:16], ln(7)[15:0], 1'b0, 1'b0, "R9 pre0");
    px(ln(8)[47:32], ln(8)[31:16], ln(8)[15:0], 1'b0, 1'b0, "R9 pre1");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 mid reset vld", {188'd0, out_lane_vld}, '0);
    chk("R9 mid reset data", out_data, '0);
    for (int k = 0; k < 4; k++)
      px(ln(k + 10)[47:32], ln(k + 10)[31:16], ln(k + 10)[15:0], 1'b0, k == 3, "R9 post");
    chk("R9 fresh word", out_data, {ln(13), ln(12), ln(11), ln(10)});
    chk("R9 fresh vld", {188'd0, out_lane_vld}, 192'hF);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule